// File: doc/BRIEF.md
# AXI Traffic Timing Profiler

This block is a passive observer placed beside one AXI connection. It samples the read address, read data, write address and write data channels and builds histograms of traffic timing. It never drives any bus signal. Each address handshake is compared against a small set of configurable flow selectors. A selector matches either on the transaction ID or on the burst length field. A transaction that matches a selector adds its timing to that flow's histograms, and one transaction may belong to several flows at once.

Six histograms are kept for every flow: read initial latency, read per-beat wait, write initial latency, write per-beat wait, read address gap and write address gap. Each histogram has eight bins. The bin width is a shared power of two, and any value past the last edge lands in the top bin. The bin counters saturate at their maximum value. Address timestamps wait in a small in-order queue for each direction. The queue assumes that data beats return in the same order as their addresses were accepted.

A registered readout port selects one flow, one histogram and one bin, and returns that count on the next clock. A synchronous clear zeroes every count, every queue, the gap history and the overflow flags, which starts a new measurement window.

Top module: `axi_traffic_profiler`

## Requirements
- R1: Read initial latency is the number of clock edges from the read address handshake to the first read data handshake of that transaction. It is binned into histogram index 0 of every flow the transaction matches.
- R2: Read wait is the number of cycles in which `rvalid` was high and `rready` low before a beat's handshake, with 0 when both are high in the same cycle. It is measured on every tracked beat and binned into histogram index 1.
- R3: Write initial latency is measured like R1, from the write address handshake to the first write data handshake. It is binned into histogram index 2.
- R4: Write wait is measured like R2 on `wvalid`/`wready` for every tracked write beat. It is binned into histogram index 3.
- R5: The gap is the number of cycles between two successive address handshakes that match the same flow. Read gaps go to index 4 and write gaps to index 5. The first matching handshake after reset or clear records no gap.
- R6: Flow f matches when `cfg_len_mode[f]`=0 and the ID equals `cfg_match_val[f]`, or when `cfg_len_mode[f]`=1 and the burst length field equals `cfg_match_val[f]`. A transaction that matches no flow changes no count.
- R7: A measured value v falls into bin min(v >> `cfg_bin_shift`, 7).
- R8: Each bin counter stops at 2^CNT_W-1 and does not wrap.
- R9: Each direction tracks at most DEPTH outstanding addresses. An address handshake while the queue is full is not timestamped and sets that direction's sticky overflow flag, but it still records its gap. A data beat with no tracked address is not binned.
- R10: A cycle with `clr` high zeroes all counts, both queues, the gap history and both overflow flags.
- R11: `rd_count` returns, one clock later, the bin selected by `sel_flow`, `sel_hist` and `sel_bin`. Histogram indices 6 and 7 and flows at or above NF read as 0.
- R12: After reset all counts, `rd_count` and both overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all statistics |
| cfg_len_mode | input | NF | Per flow: 1 matches on burst length, 0 on ID |
| cfg_match_val | input | NF x MATCH_W | Per flow match value |
| cfg_bin_shift | input | 3 | log2 of the histogram bin width |
| arvalid | input | 1 | Read address valid (observed) |
| arready | input | 1 | Read address ready (observed) |
| arid | input | ID_W | Read address ID |
| arlen | input | 8 | Read burst length field |
| rvalid | input | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rlast | input | 1 | Last read beat |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awid | input | ID_W | Write address ID |
| awlen | input | 8 | Write burst length field |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wlast | input | 1 | Last write beat |
| sel_flow | input | FSEL_W | Readout flow select |
| sel_hist | input | 3 | Readout histogram select |
| sel_bin | input | 3 | Readout bin select |
| rd_count | output | CNT_W | Selected bin count, registered |
| rd_ovf | output | 1 | Read timestamp queue overflowed |
| wr_ovf | output | 1 | Write timestamp queue overflowed |

## Verification
The assertions check the local invariants on every cycle: queue occupancy stays within its bounds, an open burst always has a queue entry, overflow flags stay set, counters hold at their ceiling, grow by at most one and read zero after a clear, and unimplemented histograms read zero. Whether a latency, wait or gap lands in the right flow, histogram and bin can only be shown by the bench's scenarios. These cover a range of wait lengths, ID and length matching, a transaction that matches both flows, a change of bin width, queue overflow with an unbinned surplus beat, saturation and the registered readout timing.

// File: rtl/atpm_pkg.sv
package atpm_pkg;

    localparam int NUM_HIST = 6;
    localparam int NUM_BINS = 8;
    localparam int BIN_W    = 3;
    localparam int HSEL_W   = 3;

    typedef enum logic [HSEL_W-1:0] {
        H_RD_INIT = 3'd0,
        H_RD_WAIT = 3'd1,
        H_WR_INIT = 3'd2,
        H_WR_WAIT = 3'd3,
        H_RD_GAP  = 3'd4,
        H_WR_GAP  = 3'd5
    } hist_e;

    typedef struct packed {
        logic             vld;
        logic [BIN_W-1:0] bin;
    } sample_t;

    // Scale by the bin width, then clamp into the last bin.
    function automatic logic [BIN_W-1:0] bin_of(input logic [31:0] value,
                                                input logic [2:0]  shift);
        logic [31:0] scaled;
        scaled = value >> shift;
        if (scaled >= 32'(NUM_BINS - 1))
            return BIN_W'(NUM_BINS - 1);
        return scaled[BIN_W-1:0];
    endfunction

endpackage

// File: rtl/atpm_tsfifo.sv
module atpm_tsfifo #(
    parameter int DEPTH = 4,
    parameter int W     = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [OCC_W-1:0] occ;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign full  = (occ == OCC_W'(DEPTH));
    assign empty = (occ == '0);
    assign head  = mem[rp];

    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));
    // R9
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R9
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/atpm_chan.sv
module atpm_chan #(
    parameter int NF      = 2,
    parameter int ID_W    = 4,
    parameter int MATCH_W = 8,
    parameter int TS_W    = 16,
    parameter int DEPTH   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic [TS_W-1:0]              now,
    input  logic [NF-1:0]                cfg_len_mode,
    input  logic [NF-1:0][MATCH_W-1:0]   cfg_val,
    input  logic                         a_valid,
    input  logic                         a_ready,
    input  logic [ID_W-1:0]              a_id,
    input  logic [7:0]                   a_len,
    input  logic                         d_valid,
    input  logic                         d_ready,
    input  logic                         d_last,
    output logic                         init_vld,
    output logic [TS_W-1:0]              init_val,
    output logic                         beat_vld,
    output logic [TS_W-1:0]              wait_val,
    output logic [NF-1:0]                beat_mask,
    output logic [NF-1:0]                gap_vld,
    output logic [NF-1:0][TS_W-1:0]      gap_val,
    output logic                         ovf
);
    localparam int EW = TS_W + NF;

    logic          a_hs, d_hs, tracked;
    logic [NF-1:0] a_mask;
    logic          q_full, q_empty, q_push, q_pop;
    logic [EW-1:0] q_head;
    logic [TS_W-1:0] head_ts;
    logic          in_burst;
    logic [TS_W-1:0] wcnt;
    logic [NF-1:0][TS_W-1:0] last_ts;
    logic [NF-1:0] last_vld;

    assign a_hs = a_valid && a_ready;
    assign d_hs = d_valid && d_ready;

    for (genvar f = 0; f < NF; f++) begin : g_match
        assign a_mask[f] = cfg_len_mode[f] ? (MATCH_W'(a_len) == cfg_val[f])
                                           : (MATCH_W'(a_id)  == cfg_val[f]);
    end

    assign q_push  = a_hs && !q_full;
    assign tracked = d_hs && !q_empty;
    assign q_pop   = tracked && d_last;

    atpm_tsfifo #(.DEPTH(DEPTH), .W(EW)) u_q (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .push  (q_push),
        .pop   (q_pop),
        .din   ({now, a_mask}),
        .full  (q_full),
        .empty (q_empty),
        .head  (q_head)
    );

    assign head_ts   = q_head[EW-1:NF];
    assign beat_mask = q_head[NF-1:0];
    assign beat_vld  = tracked;
    assign init_vld  = tracked && !in_burst;
    assign init_val  = now - head_ts;
    assign wait_val  = wcnt;

    always_ff @(posedge clk) begin
        if (rst || clr)   in_burst <= 1'b0;
        else if (tracked) in_burst <= !d_last;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                wcnt <= '0;
        else if (d_hs)                 wcnt <= '0;
        else if (d_valid && !(&wcnt))  wcnt <= wcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            last_ts  <= '0;
            last_vld <= '0;
        end else begin
            for (int f = 0; f < NF; f++) begin
                if (a_hs && a_mask[f]) begin
                    last_ts[f]  <= now;
                    last_vld[f] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int f = 0; f < NF; f++) begin
            gap_vld[f] = a_hs && a_mask[f] && last_vld[f];
            gap_val[f] = now - last_ts[f];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)           ovf <= 1'b0;
        else if (a_hs && q_full)  ovf <= 1'b1;
    end

    // R1
    burst_has_entry_chk: assert property (@(posedge clk) disable iff (rst)
        in_burst |-> !q_empty);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);
    // R2
    wait_zero_after_hs_chk: assert property (@(posedge clk) disable iff (rst)
        (d_hs && !clr) |=> (wcnt == '0 || wcnt == TS_W'(1)));

endmodule

// File: rtl/atpm_hist.sv
module atpm_hist
    import atpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  sample_t                          smp,
    output logic [NUM_BINS-1:0][CNT_W-1:0]   counts
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            counts <= '0;
        else if (smp.vld && counts[smp.bin] != CMAX)
            counts[smp.bin] <= counts[smp.bin] + 1'b1;
    end

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_chk
        // R8
        sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (counts[b] == CMAX && !clr) |=> counts[b] == CMAX);
        // R10
        clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
            clr |=> counts[b] == '0);
        // R8
        step_one_chk: assert property (@(posedge clk) disable iff (rst)
            !clr |=> (counts[b] == $past(counts[b]) ||
                      counts[b] == $past(counts[b]) + 1'b1));
    end

endmodule

// File: rtl/axi_traffic_profiler.sv
module axi_traffic_profiler
    import atpm_pkg::*;
#(
    parameter int NF      = 2,
    parameter int ID_W    = 4,
    parameter int MATCH_W = 8,
    parameter int TS_W    = 16,
    parameter int DEPTH   = 4,
    parameter int CNT_W   = 16,
    parameter int FSEL_W  = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic [NF-1:0]              cfg_len_mode,
    input  logic [NF-1:0][MATCH_W-1:0] cfg_match_val,
    input  logic [2:0]                 cfg_bin_shift,
    input  logic                       arvalid,
    input  logic                       arready,
    input  logic [ID_W-1:0]            arid,
    input  logic [7:0]                 arlen,
    input  logic                       rvalid,
    input  logic                       rready,
    input  logic                       rlast,
    input  logic                       awvalid,
    input  logic                       awready,
    input  logic [ID_W-1:0]            awid,
    input  logic [7:0]                 awlen,
    input  logic                       wvalid,
    input  logic                       wready,
    input  logic                       wlast,
    input  logic [FSEL_W-1:0]          sel_flow,
    input  logic [HSEL_W-1:0]          sel_hist,
    input  logic [BIN_W-1:0]           sel_bin,
    output logic [CNT_W-1:0]           rd_count,
    output logic                       rd_ovf,
    output logic                       wr_ovf
);
    logic [TS_W-1:0] now;

    logic                    r_init_vld, r_beat_vld, w_init_vld, w_beat_vld;
    logic [TS_W-1:0]         r_init_val, r_wait_val, w_init_val, w_wait_val;
    logic [NF-1:0]           r_mask, w_mask, r_gap_vld, w_gap_vld;
    logic [NF-1:0][TS_W-1:0] r_gap_val, w_gap_val;

    logic [NF-1:0][NUM_HIST-1:0][NUM_BINS-1:0][CNT_W-1:0] cnt_all;
    logic [CNT_W-1:0] rd_next;

    always_ff @(posedge clk) begin
        if (rst || clr) now <= '0;
        else            now <= now + 1'b1;
    end

    atpm_chan #(.NF(NF), .ID_W(ID_W), .MATCH_W(MATCH_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst(rst), .clr(clr), .now(now),
        .cfg_len_mode(cfg_len_mode), .cfg_val(cfg_match_val),
        .a_valid(arvalid), .a_ready(arready), .a_id(arid), .a_len(arlen),
        .d_valid(rvalid), .d_ready(rready), .d_last(rlast),
        .init_vld(r_init_vld), .init_val(r_init_val),
        .beat_vld(r_beat_vld), .wait_val(r_wait_val), .beat_mask(r_mask),
        .gap_vld(r_gap_vld), .gap_val(r_gap_val), .ovf(rd_ovf)
    );

    atpm_chan #(.NF(NF), .ID_W(ID_W), .MATCH_W(MATCH_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst(rst), .clr(clr), .now(now),
        .cfg_len_mode(cfg_len_mode), .cfg_val(cfg_match_val),
        .a_valid(awvalid), .a_ready(awready), .a_id(awid), .a_len(awlen),
        .d_valid(wvalid), .d_ready(wready), .d_last(wlast),
        .init_vld(w_init_vld), .init_val(w_init_val),
        .beat_vld(w_beat_vld), .wait_val(w_wait_val), .beat_mask(w_mask),
        .gap_vld(w_gap_vld), .gap_val(w_gap_val), .ovf(wr_ovf)
    );

    for (genvar f = 0; f < NF; f++) begin : g_flow
        sample_t smp [NUM_HIST];

        always_comb begin
            smp[int'(H_RD_INIT)] = '{vld: r_init_vld && r_mask[f],
                                     bin: bin_of(32'(r_init_val), cfg_bin_shift)};
            smp[int'(H_RD_WAIT)] = '{vld: r_beat_vld && r_mask[f],
                                     bin: bin_of(32'(r_wait_val), cfg_bin_shift)};
            smp[int'(H_WR_INIT)] = '{vld: w_init_vld && w_mask[f],
                                     bin: bin_of(32'(w_init_val), cfg_bin_shift)};
            smp[int'(H_WR_WAIT)] = '{vld: w_beat_vld && w_mask[f],
                                     bin: bin_of(32'(w_wait_val), cfg_bin_shift)};
            smp[int'(H_RD_GAP)]  = '{vld: r_gap_vld[f],
                                     bin: bin_of(32'(r_gap_val[f]), cfg_bin_shift)};
            smp[int'(H_WR_GAP)]  = '{vld: w_gap_vld[f],
                                     bin: bin_of(32'(w_gap_val[f]), cfg_bin_shift)};
        end

        for (genvar h = 0; h < NUM_HIST; h++) begin : g_hist
            atpm_hist #(.CNT_W(CNT_W)) u_hist (
                .clk    (clk),
                .rst    (rst),
                .clr    (clr),
                .smp    (smp[h]),
                .counts (cnt_all[f][h])
            );
        end
    end

    always_comb begin
        rd_next = '0;
        for (int f = 0; f < NF; f++) begin
            for (int h = 0; h < NUM_HIST; h++) begin
                if (32'(sel_flow) == f && 32'(sel_hist) == h)
                    rd_next = cnt_all[f][h][sel_bin];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_count <= '0;
        else     rd_count <= rd_next;
    end

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_count == '0 && !rd_ovf && !wr_ovf));
    // R11
    empty_hist_read_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_hist >= HSEL_W'(NUM_HIST)) |=> rd_count == '0);

endmodule

// File: tb/axi_traffic_profiler_tb.sv
module axi_traffic_profiler_tb;
    import atpm_pkg::*;

    localparam int NF = 2, ID_W = 4, MATCH_W = 8, TS_W = 16, DEPTH = 4, CNT_W = 6;
    localparam int FSEL_W = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, clr = 1'b0;
    logic [NF-1:0] cfg_len_mode = 2'b10;
    logic [NF-1:0][MATCH_W-1:0] cfg_match_val;
    logic [2:0] cfg_bin_shift = 3'd0;
    logic arvalid = 0, arready = 0, rvalid = 0, rready = 0, rlast = 0;
    logic awvalid = 0, awready = 0, wvalid = 0, wready = 0, wlast = 0;
    logic [ID_W-1:0] arid = '0, awid = '0;
    logic [7:0] arlen = '0, awlen = '0;
    logic [FSEL_W-1:0] sel_flow = '0;
    logic [2:0] sel_hist = '0, sel_bin = '0;
    logic [CNT_W-1:0] rd_count;
    logic rd_ovf, wr_ovf;

    axi_traffic_profiler #(.NF(NF), .ID_W(ID_W), .MATCH_W(MATCH_W), .TS_W(TS_W),
                           .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .clr(clr),
        .cfg_len_mode(cfg_len_mode), .cfg_match_val(cfg_match_val),
        .cfg_bin_shift(cfg_bin_shift),
        .arvalid(arvalid), .arready(arready), .arid(arid), .arlen(arlen),
        .rvalid(rvalid), .rready(rready), .rlast(rlast),
        .awvalid(awvalid), .awready(awready), .awid(awid), .awlen(awlen),
        .wvalid(wvalid), .wready(wready), .wlast(wlast),
        .sel_flow(sel_flow), .sel_hist(sel_hist), .sel_bin(sel_bin),
        .rd_count(rd_count), .rd_ovf(rd_ovf), .wr_ovf(wr_ovf)
    );

    typedef struct {
        int    f;
        int    h;
        int    b;
        int    val;
        string req;
    } exp_t;

    exp_t q[$];
    bit   busy = 1'b0;
    int   checks = 0;
    int   errors = 0;

    // Scoreboard monitor: pops expected bin counts and reads them back.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                busy = 1'b1;
                sel_flow = FSEL_W'(it.f);
                sel_hist = 3'(it.h);
                sel_bin  = 3'(it.b);
                @(negedge clk);
                checks++;
                if (int'(rd_count) != it.val) begin
                    errors++;
                    $display("FAIL %s flow%0d hist%0d bin%0d: actual %0d expected %0d",
                             it.req, it.f, it.h, it.b, rd_count, it.val);
                end
                busy = 1'b0;
            end
        end
    end

    task automatic expect_cnt(input int f, input int h, input int b, input int val,
                              input string req);
        exp_t it;
        it.f = f; it.h = h; it.b = b; it.val = val; it.req = req;
        q.push_back(it);
    endtask

    task automatic flush();
        wait (q.size() == 0 && !busy);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic ar(input int id, input int len);
        arvalid = 1'b1; arready = 1'b1; arid = ID_W'(id); arlen = 8'(len);
        @(negedge clk);
        arvalid = 1'b0; arready = 1'b0;
    endtask

    task automatic aw(input int id, input int len);
        awvalid = 1'b1; awready = 1'b1; awid = ID_W'(id); awlen = 8'(len);
        @(negedge clk);
        awvalid = 1'b0; awready = 1'b0;
    endtask

    task automatic rbeat(input int w, input bit last);
        rvalid = 1'b1; rlast = last; rready = (w == 0);
        for (int i = 0; i < w; i++) @(negedge clk);
        rready = 1'b1;
        @(negedge clk);
        rvalid = 1'b0; rready = 1'b0; rlast = 1'b0;
    endtask

    task automatic wbeat(input int w, input bit last);
        wvalid = 1'b1; wlast = last; wready = (w == 0);
        for (int i = 0; i < w; i++) @(negedge clk);
        wready = 1'b1;
        @(negedge clk);
        wvalid = 1'b0; wready = 1'b0; wlast = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cfg_match_val[0] = 8'd3;   // flow 0: ID == 3
        cfg_match_val[1] = 8'd3;   // flow 1: length field == 3
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12 rd_ovf", int'(rd_ovf), 0);
        chk("R12 wr_ovf", int'(wr_ovf), 0);
        expect_cnt(0, 0, 0, 0, "R12");
        flush();

        // R1, R2: read on ID flow, latency 4, wait 1
        ar(3, 0);
        idle(2);
        rbeat(1, 1);
        expect_cnt(0, 0, 4, 1, "R1");
        expect_cnt(0, 1, 1, 1, "R2");
        expect_cnt(1, 0, 4, 0, "R6 nonmatch");
        flush();

        // R2, R6, R7: length flow, four beats, waits 0,2,0,9
        ar(5, 3);
        rbeat(0, 0);
        rbeat(2, 0);
        rbeat(0, 0);
        rbeat(9, 1);
        expect_cnt(1, 0, 1, 1, "R1");
        expect_cnt(1, 1, 0, 2, "R2");
        expect_cnt(1, 1, 2, 1, "R2");
        expect_cnt(1, 1, 7, 1, "R7 clamp");
        expect_cnt(0, 1, 0, 0, "R6 nonmatch");
        flush();

        // R6, R10: transaction matching both flows after a clear
        pulse_clr();
        ar(3, 3);
        rbeat(0, 0);
        rbeat(0, 0);
        rbeat(0, 0);
        rbeat(0, 1);
        expect_cnt(0, 0, 1, 1, "R6 both");
        expect_cnt(1, 0, 1, 1, "R6 both");
        expect_cnt(0, 1, 0, 4, "R6 both");
        expect_cnt(1, 1, 0, 4, "R6 both");
        expect_cnt(0, 0, 4, 0, "R10");
        expect_cnt(1, 1, 7, 0, "R10");
        flush();

        // R5, R7: read gaps, then a wider bin
        pulse_clr();
        ar(3, 3);
        idle(4);
        ar(3, 0);
        cfg_bin_shift = 3'd2;
        idle(9);
        ar(3, 0);
        cfg_bin_shift = 3'd0;
        rbeat(0, 1);
        rbeat(0, 1);
        rbeat(0, 1);
        expect_cnt(0, 4, 5, 1, "R5");
        expect_cnt(1, 4, 5, 0, "R5 first");
        expect_cnt(0, 4, 2, 1, "R7 shift");
        flush();

        // R3, R4, R5: write side
        pulse_clr();
        aw(3, 1);
        idle(1);
        wbeat(0, 0);
        wbeat(3, 1);
        aw(3, 1);
        wbeat(0, 1);
        expect_cnt(0, 2, 2, 1, "R3");
        expect_cnt(0, 2, 1, 1, "R3");
        expect_cnt(0, 3, 0, 2, "R4");
        expect_cnt(0, 3, 3, 1, "R4");
        expect_cnt(0, 5, 7, 1, "R5");
        expect_cnt(1, 2, 2, 0, "R6 nonmatch");
        flush();

        // R9: overflow of the read queue
        pulse_clr();
        chk("R10 rd_ovf", int'(rd_ovf), 0);
        for (int i = 0; i < 5; i++) ar(3, 0);
        chk("R9 rd_ovf", int'(rd_ovf), 1);
        chk("R9 wr_ovf", int'(wr_ovf), 0);
        for (int i = 0; i < 5; i++) rbeat(0, 1);
        expect_cnt(0, 4, 1, 4, "R9 gap");
        expect_cnt(0, 0, 5, 4, "R9 latency");
        expect_cnt(0, 1, 0, 4, "R9 untracked");
        flush();
        chk("R9 sticky", int'(rd_ovf), 1);
        pulse_clr();
        chk("R10 ovf clear", int'(rd_ovf), 0);

        // R8: saturation
        for (int i = 0; i < 70; i++) ar(3, 0);
        expect_cnt(0, 4, 1, 63, "R8");
        expect_cnt(0, 6, 1, 0, "R11 unused");
        flush();

        // R11: registered readout timing
        sel_flow = 1'b0; sel_hist = 3'd4; sel_bin = 3'd1;
        @(negedge clk);
        chk("R11 select", int'(rd_count), 63);
        sel_hist = 3'd6;
        #1;
        chk("R11 held", int'(rd_count), 63);
        @(negedge clk);
        chk("R11 next", int'(rd_count), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule